// File: doc/BRIEF.md
# Completion Ring Poster

The poster records finished packets for the host. Two requesters, one for the transmit path and one for the receive path, each hand it a 31-bit completion record. The poster writes that record into the requester's own circular ring in host memory and then pulses an interrupt. Each ring has 256 word-sized slots. Each ring has its own 8-bit current index, and the index advances by one after every record the poster writes into that ring.

The host marks that it has consumed a slot by clearing the slot's ownership bit. Before every write the poster reads the target slot from memory. If the host has not yet released the slot, the poster leaves memory untouched, raises that ring's full flag and keeps the request pending. It retries until the slot becomes free. Only one memory transaction is in flight at a time. The receive path wins a tie, unless its ring is currently flagged full and the transmit ring is not. In that case the transmit request goes first, so a stalled receive ring cannot starve transmit completions.

The memory port is a simple 32-bit word port with byte addresses. Slot k of a ring lives at the ring base plus 4*k. Read data returns on the cycle after the read command.

Top module: `cring_poster`

## Requirements
- R1: While reset is asserted and after it is released, both ring indices read 0 and `irq`, `ring_full`, `tx_ack`, `rx_ack` and `mem_req` are low until a request arrives.
- R2: Every memory write is preceded, two cycles earlier, by a memory read of the same address.
- R3: If the slot read back has bit 31 set (host-owned), the poster issues no write and gives no acknowledge for that attempt. It sets `ring_full` bit 0 for the transmit ring or bit 1 for the receive ring, and it leaves that ring's index unchanged. The request stays pending and is retried.
- R4: A free slot (bit 31 clear) is written at base + 4*index with bit 31 set to 1 and bits 30:0 equal to the record. The transmit base is `TX_BASE` and the receive base is `RX_BASE`.
- R5: Each successful write increments that ring's index by one modulo 256, so 255 is followed by 0. The other ring's index is unchanged.
- R6: `irq` is high for exactly the one cycle after a successful write when `irq_en` was high during the write cycle, and it stays low otherwise.
- R7: When both directions request and neither ring is flagged full, the receive record is written first.
- R8: When the receive ring is flagged full and the transmit ring is not, a pending transmit request is served ahead of the receive retry. A ring's full flag clears on that ring's next successful write.
- R9: An acknowledge (`tx_ack` or `rx_ack`) is high for exactly the cycle of the corresponding memory write, never both at once. A first attempt takes four cycles from request to acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Enables the interrupt pulse |
| tx_req | input | 1 | Transmit completion pending; held until `tx_ack` |
| tx_rec | input | 31 | Transmit completion record |
| tx_ack | output | 1 | Transmit record written this cycle |
| rx_req | input | 1 | Receive completion pending; held until `rx_ack` |
| rx_rec | input | 31 | Receive completion record |
| rx_ack | output | 1 | Receive record written this cycle |
| irq | output | 1 | One-cycle interrupt pulse after a write |
| ring_full | output | 2 | Bit 0 transmit ring full, bit 1 receive ring full |
| tx_index | output | 8 | Current transmit ring index |
| rx_index | output | 8 | Current receive ring index |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The assertions assume the following about the block's inputs:
- Memory answers every read with valid data on the very next cycle.
- A requester holds its request and record steady until it sees its acknowledge, and then drops the request before the following edge.
- Only the host clears ownership bits, and no agent other than the poster writes a slot between the poster's read and its write.

The bench stays inside these limits. Its memory model has fixed one-cycle read latency. Its request tasks release the request on the cycle the acknowledge is seen. It changes ownership bits only through a backdoor, and only while no post is in flight.

// File: rtl/cring_pkg.sv
package cring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2,
    ST_WRITE = 2'd3
  } post_state_t;

  localparam int WORD_W  = 32;
  localparam int OWN_BIT = WORD_W - 1;
  localparam int REC_W   = WORD_W - 1;

  // byte address of a ring slot: one 32-bit word per slot
  function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                  input logic [15:0] idx);
    return base + {14'd0, idx, 2'b00};
  endfunction

  // word written to the ring: record with the host-owned mark set
  function automatic logic [WORD_W-1:0] seal_record(input logic [REC_W-1:0] rec);
    return {1'b1, rec};
  endfunction

  function automatic logic host_owns(input logic [WORD_W-1:0] word);
    return word[OWN_BIT];
  endfunction

endpackage

// File: rtl/cring_arb.sv
module cring_arb (
  input  logic       tx_req,
  input  logic       rx_req,
  input  logic [1:0] full,
  output logic       pick_valid,
  output logic       pick_rx
);
  logic rx_yields;

  // receive yields only when it is stalled and transmit is not
  assign rx_yields  = full[1] && !full[0] && tx_req;
  assign pick_rx    = rx_req && !rx_yields;
  assign pick_valid = tx_req || rx_req;
endmodule

// File: rtl/cring_idx.sv
module cring_idx #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/cring_fsm.sv
module cring_fsm
  import cring_pkg::*;
#(
  parameter int               IDX_W   = 8,
  parameter logic [WORD_W-1:0] TX_BASE = 32'h0000_1000,
  parameter logic [WORD_W-1:0] RX_BASE = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_valid,
  input  logic              pick_rx,
  input  logic [REC_W-1:0]  tx_rec,
  input  logic [REC_W-1:0]  rx_rec,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              post_fire,
  output logic              owned_hit,
  output logic              cur_rx
);
  post_state_t       st;
  logic [REC_W-1:0]  cur_rec;
  logic [WORD_W-1:0] cur_addr;
  logic [15:0]       sel_idx;

  always_comb begin
    sel_idx = '0;
    sel_idx[IDX_W-1:0] = pick_rx ? rx_idx : tx_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_rx   <= 1'b0;
      cur_rec  <= '0;
      cur_addr <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (pick_valid) begin
          cur_rx   <= pick_rx;
          cur_rec  <= pick_rx ? rx_rec : tx_rec;
          cur_addr <= slot_addr(pick_rx ? RX_BASE : TX_BASE, sel_idx);
          st       <= ST_READ;
        end
        ST_READ:  st <= ST_CHECK;
        ST_CHECK: st <= host_owns(mem_rdata) ? ST_IDLE : ST_WRITE;
        ST_WRITE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign mem_addr  = cur_addr;
  assign mem_wdata = seal_record(cur_rec);
  assign post_fire = (st == ST_WRITE);
  assign owned_hit = (st == ST_CHECK) && host_owns(mem_rdata);
endmodule

// File: rtl/cring_poster.sv
module cring_poster
  import cring_pkg::*;
#(
  parameter int                IDX_W   = 8,
  parameter logic [WORD_W-1:0] TX_BASE = 32'h0000_1000,
  parameter logic [WORD_W-1:0] RX_BASE = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              tx_req,
  input  logic [REC_W-1:0]  tx_rec,
  output logic              tx_ack,
  input  logic              rx_req,
  input  logic [REC_W-1:0]  rx_rec,
  output logic              rx_ack,
  output logic              irq,
  output logic [1:0]        ring_full,
  output logic [IDX_W-1:0]  tx_index,
  output logic [IDX_W-1:0]  rx_index,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int NRING = 2;

  logic             pick_valid, pick_rx;
  logic             post_fire, owned_hit, cur_rx;
  logic [NRING-1:0] ring_step;
  logic [IDX_W-1:0] ring_idx [NRING];

  cring_arb u_arb (
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .full      (ring_full),
    .pick_valid(pick_valid),
    .pick_rx   (pick_rx)
  );

  cring_fsm #(.IDX_W(IDX_W), .TX_BASE(TX_BASE), .RX_BASE(RX_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_valid(pick_valid),
    .pick_rx   (pick_rx),
    .tx_rec    (tx_rec),
    .rx_rec    (rx_rec),
    .tx_idx    (tx_index),
    .rx_idx    (rx_index),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .post_fire (post_fire),
    .owned_hit (owned_hit),
    .cur_rx    (cur_rx)
  );

  // ring 0 = transmit, ring 1 = receive
  assign ring_step[0] = post_fire && !cur_rx;
  assign ring_step[1] = post_fire &&  cur_rx;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    cring_idx #(.IDX_W(IDX_W)) u_idx (
      .clk  (clk),
      .rst_n(rst_n),
      .step (ring_step[g]),
      .idx  (ring_idx[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ring_full[g] <= 1'b0;
      else if (ring_step[g])                 ring_full[g] <= 1'b0;
      else if (owned_hit && (cur_rx == g[0])) ring_full[g] <= 1'b1;
    end
  end

  assign tx_index = ring_idx[0];
  assign rx_index = ring_idx[1];
  assign tx_ack   = ring_step[0];
  assign rx_ack   = ring_step[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= post_fire && irq_en;
  end
endmodule

// File: rtl/cring_poster_sva.sv
module cring_poster_sva #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             tx_ack,
  input logic             rx_ack,
  input logic             irq,
  input logic [1:0]       ring_full,
  input logic [IDX_W-1:0] tx_index,
  input logic [IDX_W-1:0] rx_index,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_rdata
);
  p_reset_clean_r1: assert property (@(posedge clk) $rose(rst_n)
      |-> (tx_index == '0) && (rx_index == '0) && !irq && (ring_full == 2'b00));

  p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($past(mem_req && !mem_we, 2) && ($past(mem_addr, 2) == mem_addr)));

  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_req && !mem_we) && mem_rdata[31]) |=> !(mem_req && mem_we));

  p_tx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |=> (tx_index == $past(tx_index) + 1'b1) && $stable(rx_index));

  p_rx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |=> (rx_index == $past(rx_index) + 1'b1) && $stable(tx_index));

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_ack || rx_ack) && irq_en) |=> irq);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past((tx_ack || rx_ack) && irq_en));

  p_full_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |=> !ring_full[0]);

  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_ack, rx_ack}));

  p_ack_is_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack || rx_ack) |-> (mem_req && mem_we));
endmodule

bind cring_poster cring_poster_sva #(.IDX_W(IDX_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_en   (irq_en),
  .tx_ack   (tx_ack),
  .rx_ack   (rx_ack),
  .irq      (irq),
  .ring_full(ring_full),
  .tx_index (tx_index),
  .rx_index (rx_index),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_rdata(mem_rdata)
);

// File: tb/cring_poster_test.sv
`timescale 1ns/1ps
module cring_poster_test;
  localparam logic [31:0] TXB = 32'h0000_1000;
  localparam logic [31:0] RXB = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_en = 1'b0;
  logic        tx_req = 1'b0, rx_req = 1'b0;
  logic [30:0] tx_rec = '0, rx_rec = '0;
  logic        tx_ack, rx_ack, irq;
  logic [1:0]  ring_full;
  logic [7:0]  tx_index, rx_index;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [512];
  logic        bd_en = 1'b0;
  logic [8:0]  bd_word = '0;
  logic [31:0] bd_val = '0;

  int checks = 0, errors = 0;
  logic [7:0] exp_tx = '0, exp_rx = '0;

  always #5 clk = ~clk;

  cring_poster #(.IDX_W(8), .TX_BASE(TXB), .RX_BASE(RXB)) uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .tx_req(tx_req), .tx_rec(tx_rec), .tx_ack(tx_ack),
    .rx_req(rx_req), .rx_rec(rx_rec), .rx_ack(rx_ack),
    .irq(irq), .ring_full(ring_full), .tx_index(tx_index), .rx_index(rx_index),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [8:0] word_of(input logic [31:0] a);
    return {a[13], a[9:2]};
  endfunction

  function automatic logic [31:0] exp_addr(input bit is_rx, input logic [7:0] k);
    return (is_rx ? RXB : TXB) + 32'(k) * 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= '0;
    end else begin
      if (bd_en) mem[bd_word] <= bd_val;
      if (mem_req) begin
        if (mem_we) mem[word_of(mem_addr)] <= mem_wdata;
        else        mem_rdata <= mem[word_of(mem_addr)];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic backdoor(input bit is_rx, input logic [7:0] k, input logic [31:0] v);
    @(negedge clk);
    bd_en = 1'b1; bd_word = {is_rx, k}; bd_val = v;
    @(negedge clk);
    bd_en = 1'b0;
  endtask

  // wait for the acknowledge of one direction, check the write, release request
  task automatic finish_post(input bit is_rx, input logic [30:0] rec, input bit ie);
    int guard = 0;
    logic [7:0] k = is_rx ? exp_rx : exp_tx;
    while (!(is_rx ? rx_ack : tx_ack) && guard < 200) begin
      @(negedge clk); guard++;
    end
    chk(guard < 200, "R9 ack seen", 32'(guard), 32'd0);
    chk(!(is_rx ? tx_ack : rx_ack), "R9 single ack", {31'd0, tx_ack & rx_ack}, 32'd0);
    chk(mem_req && mem_we, "R9 ack during write", {30'd0, mem_req, mem_we}, 32'd3);
    chk(mem_addr == exp_addr(is_rx, k), "R4 slot address", mem_addr, exp_addr(is_rx, k));
    chk(mem_wdata == {1'b1, rec}, "R4 sealed word", mem_wdata, {1'b1, rec});
    if (is_rx) rx_req = 1'b0; else tx_req = 1'b0;
    @(negedge clk);
    chk(irq == ie, "R6 irq pulse", {31'd0, irq}, {31'd0, ie});
    if (is_rx) exp_rx = exp_rx + 1'b1; else exp_tx = exp_tx + 1'b1;
    chk(tx_index == exp_tx, "R5 tx index", {24'd0, tx_index}, {24'd0, exp_tx});
    chk(rx_index == exp_rx, "R5 rx index", {24'd0, rx_index}, {24'd0, exp_rx});
    chk(!ring_full[is_rx], "R8 full clear", {30'd0, ring_full}, 32'd0);
    @(negedge clk);
    chk(!irq, "R6 irq one cycle", {31'd0, irq}, 32'd0);
    backdoor(is_rx, k, 32'd0);
  endtask

  task automatic post(input bit is_rx, input logic [30:0] rec, input bit ie);
    int cyc = 0;
    @(negedge clk);
    irq_en = ie;
    if (is_rx) begin rx_rec = rec; rx_req = 1'b1; end
    else       begin tx_rec = rec; tx_req = 1'b1; end
    while (!(tx_ack || rx_ack) && cyc < 50) begin @(negedge clk); cyc++; end
    chk(cyc == 3, "R9 first-try latency", 32'(cyc), 32'd3);
    finish_post(is_rx, rec, ie);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_index == 0 && rx_index == 0, "R1 indices in reset", {tx_index, rx_index}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!irq && ring_full == 0 && !mem_req && !tx_ack && !rx_ack, "R1 quiet after reset",
        {27'd0, irq, ring_full, mem_req, tx_ack | rx_ack}, 32'd0);

    // directed single posts, R2 read before write checked by bound assertion
    post(1'b0, 31'h1234_5678, 1'b1);
    post(1'b1, 31'h7FFF_FFFF, 1'b0);

    // R7 simultaneous requests, neither ring full
    @(negedge clk);
    irq_en = 1'b1; tx_rec = 31'h0AAA_0001; rx_rec = 31'h0BBB_0002;
    tx_req = 1'b1; rx_req = 1'b1;
    while (!(tx_ack || rx_ack)) @(negedge clk);
    chk(rx_ack && !tx_ack, "R7 receive first", {30'd0, rx_ack, tx_ack}, 32'd2);
    finish_post(1'b1, 31'h0BBB_0002, 1'b1);
    finish_post(1'b0, 31'h0AAA_0001, 1'b1);

    // R3 host-owned transmit slot blocks the post
    backdoor(1'b0, exp_tx, 32'h8000_00C3);
    @(negedge clk);
    tx_rec = 31'h0555_0055; tx_req = 1'b1;
    begin
      bit acked = 1'b0;
      repeat (12) begin @(negedge clk); if (tx_ack || (mem_req && mem_we)) acked = 1'b1; end
      chk(!acked, "R3 no write to owned slot", {31'd0, acked}, 32'd0);
    end
    chk(ring_full == 2'b01, "R3 tx full flag", {30'd0, ring_full}, 32'd1);
    chk(tx_index == exp_tx, "R3 index held", {24'd0, tx_index}, {24'd0, exp_tx});
    chk(mem[{1'b0, exp_tx}] == 32'h8000_00C3, "R3 slot intact", mem[{1'b0, exp_tx}], 32'h8000_00C3);
    backdoor(1'b0, exp_tx, 32'd0);
    finish_post(1'b0, 31'h0555_0055, 1'b1);

    // R8 stalled receive ring yields to transmit
    backdoor(1'b1, exp_rx, 32'h8000_0001);
    @(negedge clk);
    rx_rec = 31'h0123_4567; rx_req = 1'b1;
    repeat (8) @(negedge clk);
    chk(ring_full == 2'b10, "R8 rx full flag", {30'd0, ring_full}, 32'd2);
    tx_rec = 31'h0765_4321; tx_req = 1'b1;
    finish_post(1'b0, 31'h0765_4321, 1'b1);
    chk(ring_full[1], "R8 rx still full", {30'd0, ring_full}, 32'd2);
    backdoor(1'b1, exp_rx, 32'd0);
    finish_post(1'b1, 31'h0123_4567, 1'b1);

    // constrained random posts, one direction at a time
    void'($urandom(32'd1561));
    for (int n = 0; n < 200; n++) begin
      bit d  = 1'($urandom);
      bit ie = 1'($urandom);
      logic [30:0] r = 31'($urandom);
      post(d, r, ie);
    end

    // R5 wrap of the transmit index from 255 to 0
    while (exp_tx != 8'hFF) post(1'b0, 31'($urandom), 1'b0);
    post(1'b0, 31'h0000_0FF0, 1'b1);
    chk(tx_index == 8'h00, "R5 wrap to zero", {24'd0, tx_index}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule